// File: doc/BRIEF.md
# LPC I/O Cycle Target Engine

This block sits on the target side of a Low Pin Count bus. It decodes the two host-initiated I/O cycle kinds, read and write. All traffic moves over a 4-bit multiplexed address/data bus, sampled on the bus clock. An active-low frame strobe marks the start of each cycle.

During the address phase the block collects a 16-bit I/O address. It compares that address against a set of enabled address windows. When a window matches, the block claims the cycle:
- It answers with a ready sync code.
- On a read, it returns the data byte as two nibbles, low nibble first.
- It drives the final turnaround nibble.
- It raises an output enable for the bus tri-state buffers only in the slots it owns.

Reads take their byte from a local read-data input. Writes reach local logic as a one-cycle strobe that carries the address, the window index and the data byte. Local effects happen only in the last driven slot of a cycle, so a cycle the host abandons with the frame strobe leaves local state untouched.

Top module: `lpc_io_target`

## Requirements
- R1: A cycle starts only on a clock edge where `frame_n` is 0 and `nib_in` is 4'b0000. When `frame_n` is low for several edges in a row, the last such edge decides. A low-frame nibble other than 0000 starts nothing.
- R2: The nibble right after the start selects the cycle kind: 4'b0000 is an I/O read and 4'b0010 is an I/O write. The block ignores any other value and does not drive the bus for that cycle.
- R3: The address arrives over slots 3 to 6, most significant nibble first (bits 15:12, then 11:8, 7:4, 3:0). The complete address is presented on `loc_addr` from slot 7 until the cycle ends.
- R4: The address is compared with every window i whose `cfg_en[i]` is 1. Window i's address is `cfg_addr[16*i+15:16*i]`. When several windows match, the lowest index wins, and that index appears on `loc_sel`.
- R5: When no enabled window matches, the block never asserts `nib_oe`, `busy`, `wr_stb` or `rd_done` during that cycle.
- R6: In a claimed write cycle:
  - slot 7 carries data bits 3:0 and slot 8 carries bits 7:4;
  - slots 9 and 10 belong to the host;
  - the block drives 0000 (ready) in slot 11 and 1111 in slot 12;
  - the bus is released in slot 13.
- R7: In a claimed read cycle:
  - `rd_data` is sampled at the end of slot 8;
  - the block drives 0000 in slot 9, data bits 3:0 in slot 10, bits 7:4 in slot 11 and 1111 in slot 12;
  - the bus is released in slot 13.
- R8: `wr_stb` is high for exactly one cycle, slot 12 of a claimed write, with `wr_data`, `loc_addr` and `loc_sel` valid. `rd_done` is high for exactly slot 12 of a claimed read.
- R9: `busy` is high from slot 7 through slot 12 of a claimed cycle, and low at every other time.
- R10: If `frame_n` goes low during a cycle, the cycle is aborted:
  - `nib_oe` drops in that same clock cycle;
  - no strobe is issued for the aborted cycle;
  - any partial address or data is discarded;
  - if that low-frame nibble is 0000, a new cycle starts from it.
- R11: `nib_oe` is high only in the slots R6 and R7 assign to the target. It is low after reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| bus_clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_n | input | 1 | Active-low cycle frame strobe |
| nib_in | input | 4 | Nibble sampled from the multiplexed bus |
| nib_out | output | 4 | Nibble driven onto the bus when enabled |
| nib_oe | output | 1 | Tri-state enable for the bus drivers |
| cfg_addr | input | 16*NUM_WIN | Packed window addresses, window 0 in the low bits |
| cfg_en | input | NUM_WIN | Per-window enable |
| busy | output | 1 | Cycle claimed and still in progress |
| loc_addr | output | 16 | Captured I/O address |
| loc_sel | output | SEL_W | Index of the matched window |
| rd_data | input | 8 | Local read byte, sampled at the end of slot 8 |
| rd_done | output | 1 | One-cycle commit pulse for a finished read |
| wr_stb | output | 1 | One-cycle write commit strobe |
| wr_data | output | 8 | Write byte, valid with `wr_stb` |

## Verification
The checker watches these relations on every cycle:
- the output enable is never raised outside a claimed cycle, and falls whenever the frame strobe is low;
- each commit pulse lasts one cycle and coincides with the driven 1111 turnaround;
- the two commit pulses never coincide;
- the write byte and address hold still into the commit slot;
- `busy` only falls after a commit or an abort.

The nibble order, the exact slot of each target-driven value, the sampling instant of the read byte, window priority and masking, and rejection of mismatched or unsupported cycles depend on what the host sent. Only the bench's scripted cycles can show these.

// File: rtl/lpc_io_pkg.sv
package lpc_io_pkg;

    localparam int ADDR_W = 16;
    localparam int NIB_W  = 4;
    localparam int DATA_W = 8;
    localparam int ADDR_NIBS = ADDR_W / NIB_W;

    localparam logic [NIB_W-1:0] NIB_START = 4'b0000;
    localparam logic [NIB_W-1:0] CT_IO_RD  = 4'b0000;
    localparam logic [NIB_W-1:0] CT_IO_WR  = 4'b0010;
    localparam logic [NIB_W-1:0] NIB_READY = 4'b0000;
    localparam logic [NIB_W-1:0] NIB_TURN  = 4'b1111;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CTYPE,
        ST_ADDR,
        ST_WDATA,
        ST_HTAR,
        ST_SYNC,
        ST_RDATA,
        ST_STAR
    } slot_state_e;

endpackage

// File: rtl/lpc_addr_match.sv
module lpc_addr_match #(
    parameter int NUM_WIN = 4,
    parameter int SEL_W   = 2
) (
    input  logic [lpc_io_pkg::ADDR_W-1:0]         addr,
    input  logic [NUM_WIN*lpc_io_pkg::ADDR_W-1:0] cfg_addr,
    input  logic [NUM_WIN-1:0]                    cfg_en,
    output logic                                  hit,
    output logic [SEL_W-1:0]                      hit_sel
);
    import lpc_io_pkg::*;

    logic [NUM_WIN-1:0] eq_vec;

    // one comparator per window
    for (genvar gi = 0; gi < NUM_WIN; gi++) begin : g_win
        assign eq_vec[gi] = cfg_en[gi] &&
                            (cfg_addr[gi*ADDR_W +: ADDR_W] == addr);
    end

    // lowest index has priority: scan from the top, last hit wins
    always_comb begin
        hit_sel = '0;
        for (int i = NUM_WIN - 1; i >= 0; i--) begin
            if (eq_vec[i]) begin
                hit_sel = SEL_W'(i);
            end
        end
    end

    assign hit = |eq_vec;

endmodule

// File: rtl/lpc_lad_drive.sv
module lpc_lad_drive (
    input  lpc_io_pkg::slot_state_e              state,
    input  logic                                 hi_half,
    input  logic [lpc_io_pkg::DATA_W-1:0]        data,
    output logic                                 drive,
    output logic [lpc_io_pkg::NIB_W-1:0]         nib
);
    import lpc_io_pkg::*;

    always_comb begin
        drive = 1'b0;
        nib   = '0;
        unique case (state)
            ST_SYNC: begin
                drive = 1'b1;
                nib   = NIB_READY;
            end
            ST_RDATA: begin
                drive = 1'b1;
                nib   = hi_half ? data[7:4] : data[3:0];
            end
            ST_STAR: begin
                drive = 1'b1;
                nib   = NIB_TURN;
            end
            default: begin
                drive = 1'b0;
                nib   = '0;
            end
        endcase
    end

endmodule

// File: rtl/lpc_io_target.sv
module lpc_io_target #(
    parameter int NUM_WIN = 4,
    localparam int SEL_W = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1
) (
    input  logic                    bus_clk,
    input  logic                    rst_n,
    input  logic                    frame_n,
    input  logic [3:0]              nib_in,
    output logic [3:0]              nib_out,
    output logic                    nib_oe,
    input  logic [NUM_WIN*16-1:0]   cfg_addr,
    input  logic [NUM_WIN-1:0]      cfg_en,
    output logic                    busy,
    output logic [15:0]             loc_addr,
    output logic [SEL_W-1:0]        loc_sel,
    input  logic [7:0]              rd_data,
    output logic                    rd_done,
    output logic                    wr_stb,
    output logic [7:0]              wr_data
);
    import lpc_io_pkg::*;

    localparam int CNT_W = $clog2(ADDR_NIBS);
    localparam logic [CNT_W-1:0] ADDR_LAST = CNT_W'(ADDR_NIBS - 1);

    typedef struct packed {
        slot_state_e         state;
        logic                is_wr;
        logic [CNT_W-1:0]    cnt;
        logic [ADDR_W-1:0]   addr;
        logic [DATA_W-1:0]   data;
        logic [SEL_W-1:0]    sel;
    } eng_t;

    eng_t q, d;

    logic [ADDR_W-1:0] addr_shift;
    logic              m_hit;
    logic [SEL_W-1:0]  m_sel;
    logic              drv;
    logic [NIB_W-1:0]  drv_nib;

    assign addr_shift = {q.addr[ADDR_W-NIB_W-1:0], nib_in};

    lpc_addr_match #(
        .NUM_WIN (NUM_WIN),
        .SEL_W   (SEL_W)
    ) u_match (
        .addr     (addr_shift),
        .cfg_addr (cfg_addr),
        .cfg_en   (cfg_en),
        .hit      (m_hit),
        .hit_sel  (m_sel)
    );

    lpc_lad_drive u_drive (
        .state   (q.state),
        .hi_half (q.cnt[0]),
        .data    (q.data),
        .drive   (drv),
        .nib     (drv_nib)
    );

    always_comb begin
        d = q;
        if (!frame_n) begin
            // start or abort: drop any partial capture, R1 / R10
            d.state = (nib_in == NIB_START) ? ST_CTYPE : ST_IDLE;
            d.cnt   = '0;
            d.addr  = '0;
            d.data  = '0;
        end else begin
            unique case (q.state)
                ST_IDLE: begin
                    d.cnt = '0;
                end
                ST_CTYPE: begin
                    d.cnt = '0;
                    if (nib_in == CT_IO_RD) begin
                        d.state = ST_ADDR;
                        d.is_wr = 1'b0;
                    end else if (nib_in == CT_IO_WR) begin
                        d.state = ST_ADDR;
                        d.is_wr = 1'b1;
                    end else begin
                        d.state = ST_IDLE;
                    end
                end
                ST_ADDR: begin
                    d.addr = addr_shift;
                    d.cnt  = q.cnt + 1'b1;
                    if (q.cnt == ADDR_LAST) begin
                        d.cnt = '0;
                        if (m_hit) begin
                            d.sel   = m_sel;
                            d.state = q.is_wr ? ST_WDATA : ST_HTAR;
                        end else begin
                            d.state = ST_IDLE;
                        end
                    end
                end
                ST_WDATA: begin
                    if (q.cnt[0] == 1'b0) begin
                        d.data[3:0] = nib_in;
                        d.cnt       = CNT_W'(1);
                    end else begin
                        d.data[7:4] = nib_in;
                        d.cnt       = '0;
                        d.state     = ST_HTAR;
                    end
                end
                ST_HTAR: begin
                    if (q.cnt[0] == 1'b0) begin
                        d.cnt = CNT_W'(1);
                    end else begin
                        d.cnt   = '0;
                        d.state = ST_SYNC;
                        if (!q.is_wr) begin
                            d.data = rd_data;
                        end
                    end
                end
                ST_SYNC: begin
                    d.cnt   = '0;
                    d.state = q.is_wr ? ST_STAR : ST_RDATA;
                end
                ST_RDATA: begin
                    if (q.cnt[0] == 1'b0) begin
                        d.cnt = CNT_W'(1);
                    end else begin
                        d.cnt   = '0;
                        d.state = ST_STAR;
                    end
                end
                ST_STAR: begin
                    d.cnt   = '0;
                    d.state = ST_IDLE;
                end
                default: begin
                    d.state = ST_IDLE;
                end
            endcase
        end
    end

    always_ff @(posedge bus_clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{state: ST_IDLE, is_wr: 1'b0, cnt: '0,
                   addr: '0, data: '0, sel: '0};
        end else begin
            q <= d;
        end
    end

    // outputs
    assign nib_oe   = drv && frame_n;
    assign nib_out  = drv_nib;
    assign busy     = (q.state == ST_WDATA) || (q.state == ST_HTAR) ||
                      (q.state == ST_SYNC)  || (q.state == ST_RDATA) ||
                      (q.state == ST_STAR);
    assign wr_stb   = (q.state == ST_STAR) && q.is_wr  && frame_n;
    assign rd_done  = (q.state == ST_STAR) && !q.is_wr && frame_n;
    assign loc_addr = q.addr;
    assign loc_sel  = q.sel;
    assign wr_data  = q.data;

endmodule

// File: rtl/lpc_io_target_chk.sv
module lpc_io_target_chk (
    input logic        bus_clk,
    input logic        rst_n,
    input logic        frame_n,
    input logic [3:0]  nib_out,
    input logic        nib_oe,
    input logic        busy,
    input logic        wr_stb,
    input logic        rd_done,
    input logic [7:0]  wr_data,
    input logic [15:0] loc_addr
);

    assert_oe_only_when_claimed_R11: assert property (
        @(posedge bus_clk) disable iff (!rst_n)
        nib_oe |-> busy
    );

    assert_release_on_frame_R10: assert property (
        @(posedge bus_clk) disable iff (!rst_n)
        !frame_n |-> !nib_oe
    );

    assert_wr_single_pulse_R8: assert property (
        @(posedge bus_clk) disable iff (!rst_n)
        wr_stb |=> !wr_stb
    );

    assert_rd_single_pulse_R8: assert property (
        @(posedge bus_clk) disable iff (!rst_n)
        rd_done |=> !rd_done
    );

    assert_commit_exclusive_R8: assert property (
        @(posedge bus_clk) disable iff (!rst_n)
        !(wr_stb && rd_done)
    );

    assert_wr_payload_steady_R8: assert property (
        @(posedge bus_clk) disable iff (!rst_n)
        wr_stb |-> ($stable(wr_data) && $stable(loc_addr))
    );

    assert_wr_commit_turn_R6: assert property (
        @(posedge bus_clk) disable iff (!rst_n)
        wr_stb |-> (nib_oe && (nib_out == 4'b1111))
    );

    assert_rd_commit_turn_R7: assert property (
        @(posedge bus_clk) disable iff (!rst_n)
        rd_done |-> (nib_oe && (nib_out == 4'b1111))
    );

    assert_busy_ends_by_commit_or_abort_R9: assert property (
        @(posedge bus_clk) disable iff (!rst_n)
        $fell(busy) |-> ($past(wr_stb) || $past(rd_done) || !$past(frame_n))
    );

endmodule

bind lpc_io_target lpc_io_target_chk u_chk (
    .bus_clk  (bus_clk),
    .rst_n    (rst_n),
    .frame_n  (frame_n),
    .nib_out  (nib_out),
    .nib_oe   (nib_oe),
    .busy     (busy),
    .wr_stb   (wr_stb),
    .rd_done  (rd_done),
    .wr_data  (wr_data),
    .loc_addr (loc_addr)
);

// File: tb/lpc_io_target_bench.sv
`timescale 1ns/1ps
module lpc_io_target_bench;

    localparam int NUM_WIN = 4;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        frame_n;
    logic [3:0]  nib_in;
    logic [3:0]  nib_out;
    logic        nib_oe;
    logic [NUM_WIN*16-1:0] cfg_addr;
    logic [NUM_WIN-1:0]    cfg_en;
    logic        busy;
    logic [15:0] loc_addr;
    logic [1:0]  loc_sel;
    logic [7:0]  rd_data;
    logic        rd_done;
    logic        wr_stb;
    logic [7:0]  wr_data;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    lpc_io_target #(.NUM_WIN(NUM_WIN)) u_lpc_io_target (
        .bus_clk  (clk),
        .rst_n    (rst_n),
        .frame_n  (frame_n),
        .nib_in   (nib_in),
        .nib_out  (nib_out),
        .nib_oe   (nib_oe),
        .cfg_addr (cfg_addr),
        .cfg_en   (cfg_en),
        .busy     (busy),
        .loc_addr (loc_addr),
        .loc_sel  (loc_sel),
        .rd_data  (rd_data),
        .rd_done  (rd_done),
        .wr_stb   (wr_stb),
        .wr_data  (wr_data)
    );

    // {wr, addr[15:0], data[7:0], hit, sel[1:0]}
    // windows: 0=0060 1=0064 2=0CA2 3=0064 (duplicate of 1)
    localparam logic [27:0] VEC [0:7] = '{
        {1'b1, 16'h0060, 8'hA5, 1'b1, 2'd0},
        {1'b0, 16'h0060, 8'h3C, 1'b1, 2'd0},
        {1'b1, 16'h0064, 8'h96, 1'b1, 2'd1},
        {1'b0, 16'h0CA2, 8'hE1, 1'b1, 2'd2},
        {1'b1, 16'h0061, 8'hFF, 1'b0, 2'd0},
        {1'b0, 16'h1060, 8'h00, 1'b0, 2'd0},
        {1'b1, 16'h0CA2, 8'h0F, 1'b1, 2'd2},
        {1'b0, 16'h0064, 8'h80, 1'b1, 2'd1}
    };

    task automatic chk(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic slot(input logic fr, input logic [3:0] nib);
        @(negedge clk);
        frame_n = fr;
        nib_in  = nib;
        #1;
    endtask

    // One host I/O cycle with per-slot checks of the target side.
    task automatic do_io(input logic wr, input logic [3:0] ct,
                         input logic [15:0] a, input logic [7:0] d,
                         input logic h, input logic [1:0] s,
                         input int abort_k, input logic [3:0] abort_nib,
                         input bit skip_start, input bit swap_rd,
                         input logic [3:0] start_nib, input string miss_tag);
        logic [3:0] hn;
        logic       exp_oe;
        logic [3:0] exp_nib;
        rd_data = d;
        for (int k = (skip_start ? 2 : 1); k <= 13; k++) begin
            if (k == abort_k) begin
                slot(1'b0, abort_nib);
                chk("R10", "oe in abort slot", nib_oe, 1'b0);
                chk("R10", "wr_stb in abort slot", wr_stb, 1'b0);
                return;
            end
            case (k)
                1:  hn = start_nib;
                2:  hn = ct;
                3:  hn = a[15:12];
                4:  hn = a[11:8];
                5:  hn = a[7:4];
                6:  hn = a[3:0];
                7:  hn = wr ? d[3:0] : 4'hF;
                8:  hn = wr ? d[7:4] : 4'hF;
                default: hn = 4'hF;
            endcase
            slot((k == 1) ? 1'b0 : 1'b1, hn);
            if (swap_rd && k == 9) rd_data = ~d;
            exp_oe = h && (wr ? (k >= 11 && k <= 12) : (k >= 9 && k <= 12));
            chk(h ? "R11" : miss_tag, $sformatf("oe slot %0d", k), nib_oe, exp_oe);
            chk(h ? "R9" : miss_tag, $sformatf("busy slot %0d", k), busy,
                h && k >= 7 && k <= 12);
            chk(h ? "R8" : miss_tag, $sformatf("wr_stb slot %0d", k), wr_stb,
                h && wr && k == 12);
            chk(h ? "R8" : miss_tag, $sformatf("rd_done slot %0d", k), rd_done,
                h && !wr && k == 12);
            if (exp_oe) begin
                if (wr) exp_nib = (k == 11) ? 4'h0 : 4'hF;
                else case (k)
                    9:  exp_nib = 4'h0;
                    10: exp_nib = d[3:0];
                    11: exp_nib = d[7:4];
                    default: exp_nib = 4'hF;
                endcase
                chk(wr ? "R6" : "R7", $sformatf("nibble slot %0d", k),
                    nib_out, exp_nib);
            end
            if (h && k == 12) begin
                chk("R3", "loc_addr", loc_addr, a);
                chk("R4", "loc_sel", loc_sel, s);
                if (wr) chk("R6", "wr_data", wr_data, d);
            end
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        rst_n    = 1'b0;
        frame_n  = 1'b1;
        nib_in   = 4'hF;
        rd_data  = 8'h00;
        cfg_addr = {16'h0064, 16'h0CA2, 16'h0064, 16'h0060};
        cfg_en   = 4'b1111;
        repeat (3) @(negedge clk);
        #1;
        chk("R11", "oe at reset", nib_oe, 1'b0);
        chk("R9", "busy at reset", busy, 1'b0);
        chk("R8", "wr_stb at reset", wr_stb, 1'b0);
        @(negedge clk);
        rst_n = 1'b1;

        // vector table
        for (int i = 0; i < 8; i++) begin
            logic [27:0] v;
            v = VEC[i];
            do_io(v[27], v[27] ? 4'b0010 : 4'b0000, v[26:11], v[10:3],
                  v[2], v[1:0], 0, 4'h0, 1'b0, 1'b0, 4'h0, "R5");
        end

        // R4: window 1 masked, duplicate window 3 takes over
        cfg_en = 4'b1101;
        do_io(1'b0, 4'b0000, 16'h0064, 8'h5B, 1'b1, 2'd3, 0, 4'h0, 1'b0, 1'b0, 4'h0, "R4");
        // R4/R5: all windows masked
        cfg_en = 4'b0000;
        do_io(1'b1, 4'b0010, 16'h0060, 8'h11, 1'b0, 2'd0, 0, 4'h0, 1'b0, 1'b0, 4'h0, "R5");
        cfg_en = 4'b1111;

        // R2: unsupported cycle kind (0100) is ignored
        do_io(1'b0, 4'b0100, 16'h0060, 8'h22, 1'b0, 2'd0, 0, 4'h0, 1'b0, 1'b0, 4'h0, "R2");
        // R1: low-frame nibble other than 0000 starts nothing
        do_io(1'b0, 4'b0000, 16'h0060, 8'h33, 1'b0, 2'd0, 0, 4'h0, 1'b0, 1'b0, 4'h5, "R1");

        // R7: rd_data changed after slot 8 must not reach the bus
        do_io(1'b0, 4'b0000, 16'h0CA2, 8'hC6, 1'b1, 2'd2, 0, 4'h0, 1'b0, 1'b1, 4'h0, "R7");

        // R10: write aborted at its sync slot, nothing committed afterwards
        do_io(1'b1, 4'b0010, 16'h0060, 8'h77, 1'b1, 2'd0, 11, 4'hF, 1'b0, 1'b0, 4'h0, "R10");
        for (int k = 0; k < 3; k++) begin
            slot(1'b1, 4'hF);
            chk("R10", "wr_stb after abort", wr_stb, 1'b0);
            chk("R10", "busy after abort", busy, 1'b0);
        end

        // R10 + R1: read aborted in data slot by a new start, next cycle runs
        do_io(1'b0, 4'b0000, 16'h0060, 8'h44, 1'b1, 2'd0, 10, 4'h0, 1'b0, 1'b0, 4'h0, "R10");
        do_io(1'b1, 4'b0010, 16'h0CA2, 8'h9D, 1'b1, 2'd2, 0, 4'h0, 1'b1, 1'b0, 4'h0, "R1");

        // R3: address with every nibble distinct
        cfg_addr[15:0] = 16'h1234;
        do_io(1'b1, 4'b0010, 16'h1234, 8'h5E, 1'b1, 2'd0, 0, 4'h0, 1'b0, 1'b0, 4'h0, "R3");
        do_io(1'b0, 4'b0000, 16'h4321, 8'h00, 1'b0, 2'd0, 0, 4'h0, 1'b0, 1'b0, 4'h0, "R3");

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

endmodule